// File: doc/BRIEF.md
# Interrupt and Wake-Up Status Controller

This block collects event strobes from the supervisory logic of a system chip and records each one in a status flag. The events are one strobe per wake source, one per other interrupt source, and a cyclic interrupt that the block derives itself from watchdog overflows. An interrupt request line, modelled as an output enable that drives an open-drain pin low, is active while any flag is set. Software reads the flags and clears them by writing ones. It also sets a per-flag enable mask and a per-wake-source standby-control bit.

Each wake source also has a pending-wake latch beside its status flag. The latch follows different clearing rules from the flag. In Standby, clearing the flag leaves the latch set. The latch is dropped when the chip enters Normal mode, but only for sources whose standby-control bit is 0. The cyclic interrupt is armed only when the watchdog switches into timeout mode while the chip is in Normal or Standby and the watchdog-disable input is low. While armed, each watchdog overflow raises the cyclic flag.

Status bit layout: wake source i sits at bit i, the cyclic interrupt at bit NUM_WAKE, and other source j at bit NUM_WAKE+1+j. With the defaults (2 wake sources, 3 other sources) the status word is 6 bits wide. Mode encoding: 0 Normal, 1 Standby, 2 and 3 are other modes. Register addresses: 0 clears status bits by writing ones, 1 sets the enable mask, 2 sets the standby-control bits (low NUM_WAKE data bits).

Top module: `isc_ctrl`

## Requirements
- R1: `irq_drive_low` is 1 exactly when at least one bit of `status` is 1. It is evaluated in the same cycle as `status`.
- R2: A write to address 0 clears every status bit whose data bit is 1 at the next clock edge. Bits whose data bit is 0 are left unchanged.
- R3: An event strobe sets its status bit at the next edge only if the matching enable-mask bit (address 1, 1 = enabled) is 1. A masked event leaves the bit at 0. After reset every mask bit is 1.
- R4: If an enabled event and a clear of the same status bit fall in the same cycle, the bit is 1 after the edge.
- R5: A wake strobe sets its pending-wake bit whatever the mask. When the mode is Standby (1), a clear of a wake status bit leaves its pending bit set. In any other mode the clear also drops the pending bit, unless a wake strobe for that source arrives in the same cycle.
- R6: On the first edge at which the mode is Normal (0) after a cycle in another mode, a pending bit is cleared if its standby-control bit (address 2, bit i for wake source i) is 0. It stays set if that bit is 1.
- R7: `cyclic_armed` becomes 1 after an edge at which `wdt_timeout_mode` rises from 0 to 1 while the mode is Normal or Standby and `wdt_disable` is 0. It returns to 0 after any edge at which `wdt_disable` is 1 or `wdt_timeout_mode` is 0.
- R8: The cyclic status bit (bit NUM_WAKE) is set at the edge following a cycle with `cyclic_armed`, `wdt_timeout_mode` and `wdt_overflow` all 1 (subject to the mask). It is set in no other case.
- R9: After reset all status bits, pending bits, `cyclic_armed` and `irq_drive_low` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wake_evt | input | NUM_WAKE | Wake-source event strobes |
| other_evt | input | NUM_OTHER | Other interrupt event strobes |
| wdt_overflow | input | 1 | Watchdog overflow strobe |
| wdt_timeout_mode | input | 1 | Watchdog is operating in timeout mode |
| wdt_disable | input | 1 | Watchdog disable level |
| mode | input | 2 | Operating mode: 0 Normal, 1 Standby, 2/3 other |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 clear, 1 mask, 2 standby control |
| wr_data | input | NUM_WAKE+1+NUM_OTHER | Write data |
| status | output | NUM_WAKE+1+NUM_OTHER | Interrupt status flags |
| wake_pending | output | NUM_WAKE | Pending-wake latches |
| cyclic_armed | output | 1 | Cyclic interrupt is enabled |
| irq_drive_low | output | 1 | Output enable that pulls the interrupt line low |

## Verification
The bench targets the clashes between set and clear. A design that let the clear win would lose an event that arrived in the same cycle as a write of ones. A design that cleared pending wakes on every status clear would forget a Standby wake. It also drives mode entries into Normal with mixed standby-control bits, where a design that ignored those bits, or cleared on any cycle spent in Normal, would drop or keep the wrong latches. For the cyclic path it checks that a timeout entry in another mode, a disabled watchdog, or an overflow after a disarm never raises the cyclic flag.

// File: rtl/isc_pkg.sv
package isc_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_STANDBY  = 2'd1,
    MODE_SLEEP    = 2'd2,
    MODE_OVERTEMP = 2'd3
  } op_mode_e;

  localparam logic [1:0] REG_STATUS = 2'd0;
  localparam logic [1:0] REG_ENABLE = 2'd1;
  localparam logic [1:0] REG_STBCTL = 2'd2;

endpackage

// File: rtl/isc_rst_sync.sv
module isc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  assign sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/isc_status_bank.sv
module isc_status_bank #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [WIDTH-1:0] mask_wdata,
  output logic [WIDTH-1:0] status_q,
  output logic [WIDTH-1:0] mask_q
);

  logic [WIDTH-1:0] status_d;
  logic [WIDTH-1:0] mask_d;

  // Per-flag next state: a set in the same cycle overrides the clear.
  for (genvar i = 0; i < WIDTH; i++) begin : g_flag
    logic clr_hit;
    logic set_hit;
    assign clr_hit     = clr_en & clr_bits[i];
    assign set_hit     = evt[i] & mask_q[i];
    assign status_d[i] = (status_q[i] & ~clr_hit) | set_hit;
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

endmodule

// File: rtl/isc_wake_pending.sv
module isc_wake_pending
  import isc_pkg::*;
#(
  parameter int NUM_WAKE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  op_mode_e            mode,
  input  logic                clr_en,
  input  logic [NUM_WAKE-1:0] clr_bits,
  input  logic                stb_we,
  input  logic [NUM_WAKE-1:0] stb_wdata,
  output logic [NUM_WAKE-1:0] pend_q,
  output logic [NUM_WAKE-1:0] stb_q
);

  op_mode_e            mode_q;
  logic                enter_normal;
  logic                clr_allowed;
  logic [NUM_WAKE-1:0] drop;
  logic [NUM_WAKE-1:0] pend_d;
  logic [NUM_WAKE-1:0] stb_d;

  assign enter_normal = (mode == MODE_NORMAL) && (mode_q != MODE_NORMAL);
  assign clr_allowed  = clr_en && (mode != MODE_STANDBY);

  always_comb begin
    drop = '0;
    if (enter_normal) drop = drop | ~stb_q;
    if (clr_allowed)  drop = drop | clr_bits;
  end

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_src
    assign pend_d[i] = (pend_q[i] & ~drop[i]) | wake_evt[i];
  end

  always_comb begin
    stb_d = stb_q;
    if (stb_we) stb_d = stb_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      stb_q  <= '0;
      mode_q <= MODE_NORMAL;
    end else begin
      pend_q <= pend_d;
      stb_q  <= stb_d;
      mode_q <= mode;
    end
  end

endmodule

// File: rtl/isc_cyclic_arm.sv
module isc_cyclic_arm
  import isc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e mode,
  input  logic     wdt_timeout_mode,
  input  logic     wdt_disable,
  input  logic     wdt_overflow,
  output logic     arm_q,
  output logic     cyc_evt
);

  logic timeout_q;
  logic arm_d;
  logic timeout_rise;
  logic mode_ok;

  assign timeout_rise = wdt_timeout_mode & ~timeout_q;
  assign mode_ok      = (mode == MODE_NORMAL) || (mode == MODE_STANDBY);

  always_comb begin
    arm_d = arm_q;
    if (wdt_disable || !wdt_timeout_mode) arm_d = 1'b0;
    else if (timeout_rise && mode_ok)     arm_d = 1'b1;
  end

  assign cyc_evt = arm_q & wdt_timeout_mode & wdt_overflow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q     <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      arm_q     <= arm_d;
      timeout_q <= wdt_timeout_mode;
    end
  end

endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_WAKE  = 2,
  parameter int NUM_OTHER = 3,
  parameter int SYNC_LEN  = 2,
  localparam int NSTAT    = NUM_WAKE + 1 + NUM_OTHER
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WAKE-1:0]  wake_evt,
  input  logic [NUM_OTHER-1:0] other_evt,
  input  logic                 wdt_overflow,
  input  logic                 wdt_timeout_mode,
  input  logic                 wdt_disable,
  input  logic [1:0]           mode,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [NSTAT-1:0]     wr_data,
  output logic [NSTAT-1:0]     status,
  output logic [NUM_WAKE-1:0]  wake_pending,
  output logic                 cyclic_armed,
  output logic                 irq_drive_low
);

  logic             rst_int_n;
  op_mode_e         mode_e;
  logic             cyc_evt;
  logic [NSTAT-1:0] evt_all;
  logic             clr_we;
  logic             mask_we;
  logic             stb_we;
  logic [NSTAT-1:0] mask_q;
  logic [NUM_WAKE-1:0] stb_q;

  assign mode_e  = op_mode_e'(mode);
  assign clr_we  = wr_en && (wr_addr == REG_STATUS);
  assign mask_we = wr_en && (wr_addr == REG_ENABLE);
  assign stb_we  = wr_en && (wr_addr == REG_STBCTL);
  assign evt_all = {other_evt, cyc_evt, wake_evt};

  isc_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  isc_cyclic_arm u_cyc (
    .clk              (clk),
    .rst_n            (rst_int_n),
    .mode             (mode_e),
    .wdt_timeout_mode (wdt_timeout_mode),
    .wdt_disable      (wdt_disable),
    .wdt_overflow     (wdt_overflow),
    .arm_q            (cyclic_armed),
    .cyc_evt          (cyc_evt)
  );

  isc_status_bank #(.WIDTH(NSTAT)) u_bank (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .evt        (evt_all),
    .clr_en     (clr_we),
    .clr_bits   (wr_data),
    .mask_we    (mask_we),
    .mask_wdata (wr_data),
    .status_q   (status),
    .mask_q     (mask_q)
  );

  isc_wake_pending #(.NUM_WAKE(NUM_WAKE)) u_pend (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wake_evt  (wake_evt),
    .mode      (mode_e),
    .clr_en    (clr_we),
    .clr_bits  (wr_data[NUM_WAKE-1:0]),
    .stb_we    (stb_we),
    .stb_wdata (wr_data[NUM_WAKE-1:0]),
    .pend_q    (wake_pending),
    .stb_q     (stb_q)
  );

  // Open-drain line: enable the pull-down while any flag is held.
  assign irq_drive_low = |status;

endmodule

// File: rtl/isc_ctrl_checker.sv
module isc_ctrl_checker
  import isc_pkg::*;
#(
  parameter int NUM_WAKE  = 2,
  parameter int NUM_OTHER = 3,
  localparam int NSTAT    = NUM_WAKE + 1 + NUM_OTHER
) (
  input logic                 clk,
  input logic                 rst_int_n,
  input logic [NUM_WAKE-1:0]  wake_evt,
  input logic [NUM_OTHER-1:0] other_evt,
  input logic                 wdt_overflow,
  input logic                 wdt_timeout_mode,
  input logic                 wdt_disable,
  input logic [1:0]           mode,
  input logic                 wr_en,
  input logic [1:0]           wr_addr,
  input logic [NSTAT-1:0]     wr_data,
  input logic [NSTAT-1:0]     mask_q,
  input logic [NSTAT-1:0]     status,
  input logic [NUM_WAKE-1:0]  wake_pending,
  input logic                 cyclic_armed,
  input logic                 irq_drive_low
);

  localparam logic [NSTAT-1:0] CYC_ONE = NSTAT'(1) << NUM_WAKE;

  logic [NSTAT-1:0] ev_in;
  assign ev_in = {other_evt, 1'b0, wake_evt} & mask_q;

  // R1
  a_r1_irq_tracks_flags: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_drive_low == (status != '0));

  // R2
  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_addr == REG_STATUS) |=>
      ((status & $past(wr_data & ~ev_in & ~CYC_ONE)) == '0));

  // R3
  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status & ~$past(status) & ~$past(ev_in) & ~CYC_ONE) == '0);

  // R4
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ev_in != '0) |=> ((status & $past(ev_in)) == $past(ev_in)));

  // R5
  a_r5_standby_keeps_pending: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode == 2'(MODE_STANDBY)) |=>
      ((wake_pending & $past(wake_pending)) == $past(wake_pending)));

  // R5
  a_r5_wake_latches: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wake_evt != '0) |=> ((wake_pending & $past(wake_evt)) == $past(wake_evt)));

  // R7
  a_r7_disable_disarms: assert property (@(posedge clk) disable iff (!rst_int_n)
    wdt_disable |=> !cyclic_armed);

  // R8
  a_r8_cyclic_source: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(status[NUM_WAKE]) |->
      $past(cyclic_armed && wdt_timeout_mode && wdt_overflow));

endmodule

bind isc_ctrl isc_ctrl_checker #(
  .NUM_WAKE  (NUM_WAKE),
  .NUM_OTHER (NUM_OTHER)
) u_chk (
  .clk              (clk),
  .rst_int_n        (rst_int_n),
  .wake_evt         (wake_evt),
  .other_evt        (other_evt),
  .wdt_overflow     (wdt_overflow),
  .wdt_timeout_mode (wdt_timeout_mode),
  .wdt_disable      (wdt_disable),
  .mode             (mode),
  .wr_en            (wr_en),
  .wr_addr          (wr_addr),
  .wr_data          (wr_data),
  .mask_q           (mask_q),
  .status           (status),
  .wake_pending     (wake_pending),
  .cyclic_armed     (cyclic_armed),
  .irq_drive_low    (irq_drive_low)
);

// File: tb/isc_ctrl_test.sv
`timescale 1ns/1ps
module isc_ctrl_test;

  localparam int NW = 2;
  localparam int NO = 3;
  localparam int NS = NW + 1 + NO;

  logic          clk;
  logic          tb_rst_n;
  logic [NW-1:0] tb_wake;
  logic [NO-1:0] tb_oth;
  logic          tb_ovf;
  logic          tb_to;
  logic          tb_dis;
  logic [1:0]    tb_mode;
  logic          tb_we;
  logic [1:0]    tb_addr;
  logic [NS-1:0] tb_wdata;

  logic [NS-1:0] status;
  logic [NW-1:0] wake_pending;
  logic          cyclic_armed;
  logic          irq_drive_low;

  // Reference state
  logic [NS-1:0] m_status;
  logic [NS-1:0] m_mask;
  logic [NW-1:0] m_pend;
  logic [NW-1:0] m_stb;
  logic [1:0]    m_prev_mode;
  logic          m_arm;
  logic          m_to_q;

  int n_checks;
  int n_fails;

  isc_ctrl #(.NUM_WAKE(NW), .NUM_OTHER(NO)) uut (
    .clk              (clk),
    .rst_n            (tb_rst_n),
    .wake_evt         (tb_wake),
    .other_evt        (tb_oth),
    .wdt_overflow     (tb_ovf),
    .wdt_timeout_mode (tb_to),
    .wdt_disable      (tb_dis),
    .mode             (tb_mode),
    .wr_en            (tb_we),
    .wr_addr          (tb_addr),
    .wr_data          (tb_wdata),
    .status           (status),
    .wake_pending     (wake_pending),
    .cyclic_armed     (cyclic_armed),
    .irq_drive_low    (irq_drive_low)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic one_in(input int n);
    return ($urandom % n) == 0;
  endfunction

  // Next reference state from the requirements, using the current inputs.
  task automatic model_step();
    logic          cev;
    logic [NS-1:0] ev;
    logic [NS-1:0] clr;
    logic [NW-1:0] drop;
    logic          arm_n;
    cev  = m_arm && tb_to && tb_ovf;                         // R8
    ev   = {tb_oth, cev, tb_wake} & m_mask;                  // R3
    clr  = (tb_we && tb_addr == 2'd0) ? tb_wdata : '0;       // R2
    drop = '0;
    if (tb_mode == 2'd0 && m_prev_mode != 2'd0) drop = drop | ~m_stb;   // R6
    if (tb_mode != 2'd1) drop = drop | clr[NW-1:0];                   // R5
    arm_n = m_arm;                                           // R7
    if (tb_dis || !tb_to) arm_n = 1'b0;
    else if (!m_to_q && (tb_mode == 2'd0 || tb_mode == 2'd1)) arm_n = 1'b1;
    m_status = (m_status & ~clr) | ev;                       // R4
    m_pend   = (m_pend & ~drop) | tb_wake;
    if (tb_we && tb_addr == 2'd1) m_mask = tb_wdata;
    if (tb_we && tb_addr == 2'd2) m_stb  = tb_wdata[NW-1:0];
    m_arm       = arm_n;
    m_to_q      = tb_to;
    m_prev_mode = tb_mode;
  endtask

  task automatic compare_model();
    chk("R3", "status", 32'(status), 32'(m_status));
    chk("R5", "pending", 32'(wake_pending), 32'(m_pend));
    chk("R7", "armed", 32'(cyclic_armed), 32'(m_arm));
    chk("R1", "irq", 32'(irq_drive_low), 32'(m_status != '0));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_model();
    tb_wake = '0;
    tb_oth  = '0;
    tb_ovf  = 1'b0;
    tb_we   = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
    tb_we = 1'b1; tb_addr = a; tb_wdata = d;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    n_checks = 0; n_fails = 0;
    void'($urandom(32'd20240611));
    tb_rst_n = 1'b0; tb_wake = '0; tb_oth = '0; tb_ovf = 1'b0; tb_to = 1'b0;
    tb_dis = 1'b0; tb_mode = 2'd0; tb_we = 1'b0; tb_addr = '0; tb_wdata = '0;
    m_status = '0; m_mask = '1; m_pend = '0; m_stb = '0;
    m_prev_mode = 2'd0; m_arm = 1'b0; m_to_q = 1'b0;
    repeat (3) @(negedge clk);
    tb_rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9", "status", 32'(status), 32'd0);
    chk("R9", "pending", 32'(wake_pending), 32'd0);
    chk("R9", "armed", 32'(cyclic_armed), 32'd0);
    chk("R9", "irq", 32'(irq_drive_low), 32'd0);

    // R3 / R1 : enabled wake sets flag and line
    tb_wake = 2'b01; tick();
    chk("R3", "wake0 set", 32'(status), 32'h01);
    chk("R1", "irq on", 32'(irq_drive_low), 32'd1);

    // R2 : zeros leave, ones clear
    wr(2'd0, 6'b111110); tick();
    chk("R2", "zero keeps", 32'(status), 32'h01);
    wr(2'd0, 6'b000001); tick();
    chk("R2", "one clears", 32'(status), 32'h00);
    chk("R1", "irq off", 32'(irq_drive_low), 32'd0);
    chk("R5", "normal clear drops pending", 32'(wake_pending), 32'h0);

    // R4 : event and clear together
    tb_wake = 2'b10; wr(2'd0, 6'b000010); tick();
    chk("R4", "event wins", 32'(status), 32'h02);
    wr(2'd0, 6'b000010); tick();

    // R3 : masked other source
    wr(2'd1, ~6'b001000); tick();
    tb_oth = 3'b001; tick();
    chk("R3", "masked event", 32'(status), 32'h00);
    wr(2'd1, 6'b111111); tick();
    tb_oth = 3'b001; tick();
    chk("R3", "unmasked event", 32'(status), 32'h08);
    wr(2'd0, 6'b001000); tick();

    // R5 : standby clear keeps pending
    tb_mode = 2'd1; tick();
    tb_wake = 2'b01; tick();
    wr(2'd0, 6'b000001); tick();
    chk("R5", "standby status", 32'(status), 32'h00);
    chk("R5", "standby pending", 32'(wake_pending), 32'h1);
    tb_mode = 2'd2; wr(2'd0, 6'b000001); tick();
    chk("R5", "other-mode clear", 32'(wake_pending), 32'h0);

    // R6 : entry into Normal honours standby control
    wr(2'd2, 6'b000010); tick();
    tb_mode = 2'd1; tick();
    tb_wake = 2'b11; tick();
    wr(2'd0, 6'b000011); tick();
    chk("R6", "held in standby", 32'(wake_pending), 32'h3);
    tb_mode = 2'd0; tick();
    chk("R6", "normal entry", 32'(wake_pending), 32'h2);
    tick();
    chk("R6", "stays in normal", 32'(wake_pending), 32'h2);
    tb_mode = 2'd1; wr(2'd2, 6'b000000); tick();
    tb_mode = 2'd0; tick();
    chk("R6", "second entry", 32'(wake_pending), 32'h0);

    // R7 / R8 : cyclic arming and overflow
    tb_to = 1'b1; tick();
    chk("R7", "armed on entry", 32'(cyclic_armed), 32'd1);
    tb_ovf = 1'b1; tick();
    chk("R8", "cyclic flag", 32'(status), 32'h04);
    chk("R1", "irq cyclic", 32'(irq_drive_low), 32'd1);
    wr(2'd0, 6'b000100); tick();
    tb_dis = 1'b1; tick();
    chk("R7", "disable disarms", 32'(cyclic_armed), 32'd0);
    tb_dis = 1'b0; tb_ovf = 1'b1; tick();
    chk("R8", "no flag when disarmed", 32'(status), 32'h00);
    tb_to = 1'b0; tick();
    tb_mode = 2'd2; tb_to = 1'b1; tick();
    chk("R7", "no arm in other mode", 32'(cyclic_armed), 32'd0);
    tb_ovf = 1'b1; tick();
    chk("R8", "no flag other mode", 32'(status), 32'h00);
    tb_to = 1'b0; tb_mode = 2'd0; tick();

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      if (one_in(16)) tb_mode = 2'($urandom % 4);
      if (one_in(20)) tb_to = ~tb_to;
      tb_dis = one_in(40);
      tb_ovf = one_in(4);
      for (int b = 0; b < NW; b++) tb_wake[b] = one_in(10);
      for (int b = 0; b < NO; b++) tb_oth[b] = one_in(10);
      if (one_in(4)) begin
        tb_we = 1'b1;
        tb_addr = 2'($urandom % 4);
        tb_wdata = NS'($urandom);
        if (tb_addr == 2'd1 && !one_in(3)) tb_wdata = '1;
      end
      tick();
    end

    summary();
  end

endmodule